// File: doc/BRIEF.md
# Six-slot VLIW execution core with delayed writeback

The core fetches one 192-bit very-long instruction word per clock from an external instruction port and issues all six of its operation slots at once. The slots are two integer ALUs, two load/store units, one FP adder and one FP multiplier. Operands are read from two 32-entry register files (integer and FP) at issue. The result is carried down a fixed delay line matched to the unit's latency, and is written when it leaves that line. There is no interlock and no scoreboard. A register keeps returning its previous contents until the delayed write aimed at it lands, so software schedules around every hazard. The FP units compute integer sums and products as stand-ins for floating-point arithmetic.

Slot j sits in word bits [32j+31:32j], in the order ALU0 (j=0), ALU1, MEM0, MEM1, FADD, FMUL (j=5). Each slot has the fields op[31:28], rd[27:23], ra[22:18], rb[17:13] and a signed immediate imm[12:0]. The op codes are:

- 0: no-op
- 1: integer add (rd = ra + rb)
- 2: add immediate (rd = ra + imm)
- 3: branch if integer ra is nonzero, to word address imm
- 4: integer load (int rd = mem[ra + imm])
- 5: integer store (mem[ra + imm] = int rb)
- 6: FP load (fp rd = mem[ra + imm])
- 7: FP store (mem[ra + imm] = fp rb)
- 8: FP add (fp rd = fp ra + fp rb)
- 9: FP multiply (fp rd = fp ra * fp rb)

Memory addresses are word indices into a small internal data memory. A read-only peek port shows one register of each file, so the state can be observed.

Top module: `vliw_core`

## Requirements
- R1: Reset is active-low and asynchronous. While it is held and just after it, the fetch address is 0 and every register of both files reads 0. No operation issued before the reset writes anything after it.
- R2: An ALU add (code 1) or add-immediate (code 2) issued in one word is visible to the operands of the very next word.
- R3: A load (code 4 or 6) writes its register three cycles after issue. Reads during the two words in between return the old value, including an older ALU result written to the same register.
- R4: An FP add (code 8, slot 4) or multiply (code 9, slot 5) writes its register four cycles after issue. Until then, reads return the previous contents.
- R5: Issue never stalls. Without a taken branch, the fetch address rises by one every cycle, whatever the dependences between words.
- R6: A branch (code 3) whose integer ra is nonzero sets the next fetch address to imm[7:0], with no delay slot. A branch on a zero register falls through. If both ALU slots take a branch, the slot 1 target is used.
- R7: Operations issued in the same word as a taken branch, or earlier, still complete and write back.
- R8: When several retiring results target the same register at the same edge, the one from the higher-numbered slot is kept. This holds both within one unit class and across classes (for example, a load in slot 2 over an ALU result in slot 0).
- R9: A store reads its address and data at issue and updates memory three cycles later. A load that retires at the same edge sees the old word. A load retiring one cycle later sees the new word.
- R10: A slot holding code 0, or a code outside that slot's class, changes no register and no memory word, whatever its other fields contain.
- R11: Each FP unit accepts a new operation every cycle. Back-to-back operations to the same register land on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | PC_W | Word address of the instruction to fetch |
| imem_word | input | 6*32 | Instruction word at imem_addr, same cycle |
| peek_idx | input | log2(NREG) | Register index for the peek outputs |
| peek_int | output | DATA_W | Integer register selected by peek_idx |
| peek_fp | output | DATA_W | FP register selected by peek_idx |

## Verification
The bench builds the core with its default parameters: 32-bit data, 32 registers per file, an 8-bit fetch address and a 16-word data memory. With these settings, the test programs can place branch targets as far apart as word 30 and can reach the data-memory addresses 1 through 8. The 32-bit data width holds the products of the multiplier tests without truncation. A single scheduled program lets the bench observe each latency boundary, the old-value windows and the same-edge write collisions. A second program covers taken, untaken and double branches.

// File: rtl/vliw_pkg.sv
package vliw_pkg;

   localparam int NSLOT   = 6;
   localparam int LAT_ALU = 1;
   localparam int LAT_MEM = 3;
   localparam int LAT_FP  = 4;

   typedef enum logic [3:0] {
      OP_NOP  = 4'd0,
      OP_ADD  = 4'd1,
      OP_ADDI = 4'd2,
      OP_BNEZ = 4'd3,
      OP_LDI  = 4'd4,
      OP_STI  = 4'd5,
      OP_LDF  = 4'd6,
      OP_STF  = 4'd7,
      OP_FADD = 4'd8,
      OP_FMUL = 4'd9
   } op_e;

   typedef struct packed {
      logic [3:0]  op;
      logic [4:0]  rd;
      logic [4:0]  ra;
      logic [4:0]  rb;
      logic [12:0] imm;
   } slot_t;

   localparam int SLOT_W = $bits(slot_t);

endpackage

// File: rtl/vliw_delay_pipe.sv
module vliw_delay_pipe #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (DEPTH < 1 || W < 1) begin : g_bad_param
      $error("vliw_delay_pipe: DEPTH and W must be at least 1");
   end

   logic [DEPTH-1:0][W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr[0] <= '0;
      else        sr[0] <= din;
   end

   for (genvar i = 1; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr[i] <= '0;
         else        sr[i] <= sr[i-1];
      end
   end

   assign dout = sr[DEPTH-1];

endmodule

// File: rtl/vliw_regfile.sv
module vliw_regfile #(
   parameter int DATA_W = 32,
   parameter int NREG   = 32,
   parameter int NWP    = 4,
   localparam int RIDX  = $clog2(NREG)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NWP-1:0]               we,
   input  logic [NWP-1:0][RIDX-1:0]     wa,
   input  logic [NWP-1:0][DATA_W-1:0]   wd,
   output logic [NREG-1:0][DATA_W-1:0]  q
);

   if ((1 << RIDX) != NREG || NREG > 32 || NWP < 1) begin : g_bad_param
      $error("vliw_regfile: NREG must be a power of two up to 32");
   end

   // ports are applied in ascending order so the highest slot wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         for (int p = 0; p < NWP; p++) begin
            if (we[p]) q[wa[p]] <= wd[p];
         end
      end
   end

endmodule

// File: rtl/vliw_dmem.sv
module vliw_dmem #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int NP     = 2,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NP-1:0]              we,
   input  logic [NP-1:0][AW-1:0]      addr,
   input  logic [NP-1:0][DATA_W-1:0]  wd,
   output logic [NP-1:0][DATA_W-1:0]  rd
);

   if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_param
      $error("vliw_dmem: DEPTH must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         for (int p = 0; p < NP; p++) begin
            if (we[p]) mem[addr[p]] <= wd[p];
         end
      end
   end

   for (genvar p = 0; p < NP; p++) begin : g_rd
      assign rd[p] = mem[addr[p]];
   end

endmodule

// File: rtl/vliw_core.sv
module vliw_core
   import vliw_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NREG       = 32,
   parameter int PC_W       = 8,
   parameter int DMEM_DEPTH = 16,
   localparam int RIDX      = $clog2(NREG),
   localparam int WORD_W    = NSLOT * SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [PC_W-1:0]   imem_addr,
   input  logic [WORD_W-1:0] imem_word,
   input  logic [RIDX-1:0]   peek_idx,
   output logic [DATA_W-1:0] peek_int,
   output logic [DATA_W-1:0] peek_fp
);

   localparam int DMEM_AW = $clog2(DMEM_DEPTH);

   if (DATA_W < 13 || PC_W > 13 || PC_W < 1) begin : g_bad_param
      $error("vliw_core: DATA_W must be >= 13 and PC_W in 1..13");
   end

   typedef struct packed {
      logic              v;
      logic [RIDX-1:0]   rd;
      logic [DATA_W-1:0] d;
   } wb_t;

   typedef struct packed {
      logic               v;
      logic               st;
      logic               fp;
      logic [RIDX-1:0]    rd;
      logic [DMEM_AW-1:0] a;
      logic [DATA_W-1:0]  d;
   } mop_t;

   function automatic logic [DATA_W-1:0] sext13(input logic [12:0] v);
      return {{(DATA_W-13){v[12]}}, v};
   endfunction

   slot_t                       sl [NSLOT];
   logic [NREG-1:0][DATA_W-1:0] ireg, freg;
   logic [PC_W-1:0]             pc;
   logic                        take [2];
   logic [PC_W-1:0]             tgt  [2];
   wb_t                         alu_wb [2];
   mop_t                        m_iss [2];
   mop_t                        m_ret [2];
   wb_t                         f_iss [2];
   wb_t                         f_ret [2];
   logic [1:0]                  dm_we;
   logic [1:0][DMEM_AW-1:0]     dm_addr;
   logic [1:0][DATA_W-1:0]      dm_wd, dm_rd;
   logic [3:0]                  iwe, fwe;
   logic [3:0][RIDX-1:0]        iwa, fwa;
   logic [3:0][DATA_W-1:0]      iwd, fwd;

   for (genvar g = 0; g < NSLOT; g++) begin : g_split
      assign sl[g] = imem_word[g*SLOT_W +: SLOT_W];
   end

   // ---------------- integer ALU slots (latency 1, no delay line) --------
   for (genvar a = 0; a < 2; a++) begin : g_alu
      always_comb begin
         alu_wb[a].v  = (sl[a].op == OP_ADD) || (sl[a].op == OP_ADDI);
         alu_wb[a].rd = sl[a].rd[RIDX-1:0];
         alu_wb[a].d  = ireg[sl[a].ra[RIDX-1:0]] +
                        ((sl[a].op == OP_ADD) ? ireg[sl[a].rb[RIDX-1:0]]
                                               : sext13(sl[a].imm));
         take[a]      = (sl[a].op == OP_BNEZ) &&
                        (ireg[sl[a].ra[RIDX-1:0]] != '0);
         tgt[a]       = sl[a].imm[PC_W-1:0];
      end
   end

   // ---------------- load/store slots (latency 3) -------------------------
   for (genvar j = 0; j < 2; j++) begin : g_mem
      always_comb begin
         m_iss[j].v  = (sl[2+j].op == OP_LDI) || (sl[2+j].op == OP_STI) ||
                       (sl[2+j].op == OP_LDF) || (sl[2+j].op == OP_STF);
         m_iss[j].st = (sl[2+j].op == OP_STI) || (sl[2+j].op == OP_STF);
         m_iss[j].fp = (sl[2+j].op == OP_LDF) || (sl[2+j].op == OP_STF);
         m_iss[j].rd = sl[2+j].rd[RIDX-1:0];
         m_iss[j].a  = DMEM_AW'(ireg[sl[2+j].ra[RIDX-1:0]] + sext13(sl[2+j].imm));
         m_iss[j].d  = (sl[2+j].op == OP_STF) ? freg[sl[2+j].rb[RIDX-1:0]]
                                              : ireg[sl[2+j].rb[RIDX-1:0]];
      end

      vliw_delay_pipe #(.W($bits(mop_t)), .DEPTH(LAT_MEM-1)) u_mpipe (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (m_iss[j]),
         .dout (m_ret[j])
      );

      assign dm_we[j]   = m_ret[j].v && m_ret[j].st;
      assign dm_addr[j] = m_ret[j].a;
      assign dm_wd[j]   = m_ret[j].d;

      // R3
      mem_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         m_ret[j].v |-> $past(m_iss[j].v, 2));
   end

   // ---------------- FP slots (latency 4), adder and multiplier variants --
   for (genvar k = 0; k < 2; k++) begin : g_fp
      if (k == 0) begin : g_add
         always_comb begin
            f_iss[k].v  = (sl[4+k].op == OP_FADD);
            f_iss[k].rd = sl[4+k].rd[RIDX-1:0];
            f_iss[k].d  = freg[sl[4+k].ra[RIDX-1:0]] + freg[sl[4+k].rb[RIDX-1:0]];
         end
      end else begin : g_mul
         always_comb begin
            f_iss[k].v  = (sl[4+k].op == OP_FMUL);
            f_iss[k].rd = sl[4+k].rd[RIDX-1:0];
            f_iss[k].d  = freg[sl[4+k].ra[RIDX-1:0]] * freg[sl[4+k].rb[RIDX-1:0]];
         end
      end

      vliw_delay_pipe #(.W($bits(wb_t)), .DEPTH(LAT_FP-1)) u_fpipe (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (f_iss[k]),
         .dout (f_ret[k])
      );

      // R4
      fp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         f_ret[k].v |-> $past(f_iss[k].v, 3));
   end

   vliw_dmem #(.DATA_W(DATA_W), .DEPTH(DMEM_DEPTH), .NP(2)) u_dmem (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (dm_we),
      .addr (dm_addr),
      .wd   (dm_wd),
      .rd   (dm_rd)
   );

   // ---------------- write ports, in slot order ---------------------------
   always_comb begin
      for (int a = 0; a < 2; a++) begin
         iwe[a] = alu_wb[a].v;
         iwa[a] = alu_wb[a].rd;
         iwd[a] = alu_wb[a].d;
      end
      for (int j = 0; j < 2; j++) begin
         iwe[2+j] = m_ret[j].v && !m_ret[j].st && !m_ret[j].fp;
         iwa[2+j] = m_ret[j].rd;
         iwd[2+j] = dm_rd[j];
         fwe[j]   = m_ret[j].v && !m_ret[j].st && m_ret[j].fp;
         fwa[j]   = m_ret[j].rd;
         fwd[j]   = dm_rd[j];
      end
      for (int k = 0; k < 2; k++) begin
         fwe[2+k] = f_ret[k].v;
         fwa[2+k] = f_ret[k].rd;
         fwd[2+k] = f_ret[k].d;
      end
   end

   vliw_regfile #(.DATA_W(DATA_W), .NREG(NREG), .NWP(4)) u_irf (
      .clk(clk), .rst_n(rst_n), .we(iwe), .wa(iwa), .wd(iwd), .q(ireg)
   );

   vliw_regfile #(.DATA_W(DATA_W), .NREG(NREG), .NWP(4)) u_frf (
      .clk(clk), .rst_n(rst_n), .we(fwe), .wa(fwa), .wd(fwd), .q(freg)
   );

   assign peek_int = ireg[peek_idx];
   assign peek_fp  = freg[peek_idx];

   // ---------------- fetch ------------------------------------------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pc <= '0;
      else if (take[1]) pc <= tgt[1];
      else if (take[0]) pc <= tgt[0];
      else              pc <= pc + 1'b1;
   end

   assign imem_addr = pc;

   // R6
   redirect_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take[1] |=> (imem_addr == $past(tgt[1])));

   // R6
   redirect_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take[0] && !take[1]) |=> (imem_addr == $past(tgt[0])));

   // R5
   no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!take[0] && !take[1]) |=> (imem_addr == $past(imem_addr) + 1'b1));

endmodule

// File: tb/vliw_core_test.sv
module vliw_core_test;

   localparam int PERIOD = 10;
   localparam int NT     = 28;

   // fields: cycle[54:47] kind[46:45] (0 int,1 fp,2 fetch addr) idx[44:40] exp[39:8] req[7:0]
   localparam logic [54:0] TBL [NT] = '{
      {8'd0,  2'd2, 5'd0,  32'd0,  8'd1},   // R1
      {8'd0,  2'd0, 5'd1,  32'd0,  8'd1},   // R1
      {8'd0,  2'd1, 5'd1,  32'd0,  8'd1},   // R1
      {8'd1,  2'd0, 5'd1,  32'd5,  8'd2},   // R2
      {8'd1,  2'd0, 5'd2,  32'd7,  8'd2},   // R2
      {8'd2,  2'd0, 5'd3,  32'd12, 8'd2},   // R2
      {8'd2,  2'd0, 5'd1,  32'd6,  8'd2},   // R2
      {8'd3,  2'd0, 5'd4,  32'd9,  8'd3},   // R3
      {8'd3,  2'd2, 5'd0,  32'd3,  8'd5},   // R5
      {8'd4,  2'd0, 5'd4,  32'd9,  8'd3},   // R3
      {8'd5,  2'd0, 5'd4,  32'd7,  8'd3},   // R3
      {8'd5,  2'd1, 5'd1,  32'd0,  8'd3},   // R3
      {8'd6,  2'd1, 5'd1,  32'd7,  8'd3},   // R3
      {8'd6,  2'd1, 5'd2,  32'd5,  8'd9},   // R9
      {8'd9,  2'd2, 5'd0,  32'd9,  8'd5},   // R5
      {8'd9,  2'd1, 5'd3,  32'd0,  8'd4},   // R4
      {8'd9,  2'd0, 5'd6,  32'd2,  8'd8},   // R8
      {8'd10, 2'd1, 5'd3,  32'd12, 8'd4},   // R4
      {8'd10, 2'd1, 5'd4,  32'd35, 8'd4},   // R4
      {8'd11, 2'd1, 5'd4,  32'd49, 8'd11},  // R11
      {8'd11, 2'd1, 5'd3,  32'd7,  8'd4},   // R4
      {8'd11, 2'd0, 5'd7,  32'd7,  8'd8},   // R8
      {8'd11, 2'd0, 5'd3,  32'd1,  8'd9},   // R9
      {8'd12, 2'd0, 5'd7,  32'd7,  8'd8},   // R8
      {8'd12, 2'd0, 5'd1,  32'd6,  8'd10},  // R10
      {8'd12, 2'd1, 5'd1,  32'd7,  8'd10},  // R10
      {8'd12, 2'd0, 5'd9,  32'd7,  8'd9},   // R9
      {8'd13, 2'd0, 5'd10, 32'd12, 8'd9}    // R9
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   imem_addr;
   logic [191:0] imem_word;
   logic [4:0]   peek_idx = '0;
   logic [31:0]  peek_int, peek_fp;
   logic [191:0] rom [256];
   int           n_chk = 0;
   int           n_fail = 0;

   always #(PERIOD/2) clk = ~clk;

   assign imem_word = rom[imem_addr];

   vliw_core uut (
      .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_word(imem_word),
      .peek_idx(peek_idx), .peek_int(peek_int), .peek_fp(peek_fp)
   );

   function automatic logic [31:0] enc(input int op, input int rd, input int ra,
                                       input int rb, input int imm);
      return {op[3:0], rd[4:0], ra[4:0], rb[4:0], imm[12:0]};
   endfunction

   task automatic put(input int w, input int slot, input logic [31:0] v);
      rom[w][slot*32 +: 32] = v;
   endtask

   task automatic clear_rom();
      for (int i = 0; i < 256; i++) rom[i] = '0;
   endtask

   task automatic sample(input int kind, input int idx, output logic [31:0] got);
      if (kind == 2) begin
         got = 32'(imem_addr);
      end else begin
         peek_idx = idx[4:0];
         #1;
         got = (kind == 1) ? peek_fp : peek_int;
      end
   endtask

   task automatic check(input int req, input int kind, input int idx, input logic [31:0] exp);
      logic [31:0] got;
      sample(kind, idx, got);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL R%0d kind %0d idx %0d: actual %0d expected %0d", req, kind, idx, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic restart();
      @(negedge clk);
      rst_n = 1'b0;
      step();
      step();
      rst_n = 1'b1;
   endtask

   // op codes: 1 add, 2 addi, 3 bnez, 4 ld int, 5 st int, 6 ld fp, 7 st fp, 8 fadd, 9 fmul
   task automatic load_prog_a();
      clear_rom();
      put(0, 0, enc(2, 1, 0, 0, 5));
      put(0, 1, enc(2, 2, 0, 0, 7));
      put(1, 0, enc(1, 3, 1, 2, 0));
      put(1, 1, enc(2, 1, 1, 0, 1));
      put(1, 2, enc(5, 0, 0, 2, 3));
      put(1, 3, enc(5, 0, 0, 1, 5));
      put(2, 0, enc(2, 4, 0, 0, 9));
      put(2, 3, enc(4, 4, 0, 0, 3));
      put(3, 2, enc(6, 1, 0, 0, 3));
      put(3, 3, enc(6, 2, 1, 0, -1));
      put(4, 2, enc(5, 0, 0, 2, 8));
      put(6, 4, enc(8, 3, 1, 2, 0));
      put(6, 5, enc(9, 4, 1, 2, 0));
      put(7, 4, enc(8, 3, 3, 1, 0));
      put(7, 5, enc(9, 4, 1, 1, 0));
      put(8, 0, enc(2, 6, 0, 0, 1));
      put(8, 1, enc(2, 6, 0, 0, 2));
      put(8, 2, enc(4, 7, 0, 0, 3));
      put(9, 0, enc(0, 1, 2, 2, 55));
      put(9, 1, enc(8, 1, 2, 2, 3));
      put(9, 2, enc(5, 0, 0, 3, 8));
      put(9, 3, enc(4, 9, 0, 0, 8));
      put(9, 4, enc(0, 1, 2, 2, 0));
      put(9, 5, enc(8, 1, 2, 2, 0));
      put(10, 0, enc(2, 7, 0, 0, 100));
      put(10, 1, enc(2, 3, 0, 0, 1));
      put(10, 3, enc(4, 10, 0, 0, 8));
   endtask

   task automatic load_prog_b();
      clear_rom();
      put(0, 0, enc(2, 1, 0, 0, 1));
      put(0, 1, enc(2, 5, 0, 0, 3));
      put(1, 0, enc(2, 4, 5, 0, 1));
      put(1, 1, enc(3, 0, 1, 0, 6));
      put(1, 2, enc(5, 0, 0, 5, 1));
      for (int w = 2; w < 6; w++) put(w, 0, enc(2, 7, 0, 0, 99));
      put(6, 2, enc(4, 6, 0, 0, 1));
      put(7, 0, enc(3, 0, 1, 0, 20));
      put(7, 1, enc(3, 0, 1, 0, 30));
      put(8, 0, enc(2, 7, 0, 0, 99));
      put(20, 0, enc(2, 7, 0, 0, 55));
      put(30, 0, enc(3, 0, 0, 0, 0));
      put(31, 0, enc(2, 9, 0, 0, 2));
   endtask

   initial begin
      #(PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      load_prog_a();
      restart();

      // table walk over program A, one sample point per cycle
      for (int k = 0; k <= 14; k++) begin
         for (int e = 0; e < NT; e++) begin
            if (int'(TBL[e][54:47]) == k)
               check(int'(TBL[e][7:0]), int'(TBL[e][46:45]), int'(TBL[e][44:40]), TBL[e][39:8]);
         end
         step();
      end

      // R1: reset in the middle of program A with FP ops in flight
      restart();
      step();
      step();
      check(1, 2, 0, 32'd2);
      check(1, 1, 4, 32'd0);
      step();
      step();
      step();
      check(1, 1, 3, 32'd0);
      check(1, 1, 4, 32'd0);

      // R6, R7: branch program
      load_prog_b();
      restart();
      step();
      check(5, 2, 0, 32'd1);          // R5
      step();
      check(6, 2, 0, 32'd6);          // R6 taken, no delay slot
      check(7, 0, 4, 32'd4);          // R7 same-word ALU op completes
      step();
      check(6, 2, 0, 32'd7);          // R6
      step();
      check(6, 2, 0, 32'd30);         // R6 slot 1 target wins
      check(7, 0, 6, 32'd0);          // R7 load not yet landed
      step();
      check(6, 2, 0, 32'd31);         // R6 zero register falls through
      check(7, 0, 6, 32'd3);          // R7 store from branch word landed
      step();
      check(6, 0, 9, 32'd2);          // R6
      check(6, 0, 7, 32'd0);          // R6 skipped words never issued

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule